// File: doc/BRIEF.md
# Periodic Timeout Scanner

This block implements timed waits for a fixed table of process records in memory. Each record is five words long; word 2 holds a timeout deadline and word 3 holds a flags word whose bit 3 marks a process that is waiting on a condition. A slow tick input is prescaled by a small down counter. When the counter runs out, the block reads a current-time word from memory, increments it and writes it back. It then walks the record table from a first address to a last address in five-word steps.

Each record whose nonzero timeout equals the new time is handed to an external requeue engine through a request/acknowledge handshake, so that the process is placed on the ready queue. The block then clears the waiting bit in that record's flags word. Memory is reached through a single-word request/acknowledge port that carries one access at a time.

A separate combinational path computes the deadline stored when a wait begins. A zero interval means "wait forever" and yields a zero deadline. Any other interval is added to the current time, modulo 2^16. Because zero is reserved for "no timeout", a sum that wraps to zero is replaced by one.

Top module: `tmo_scanner`

## Requirements
- R1: After reset the prescale counter holds 3. Every accepted tick decrements it. The tick that takes it from 1 to 0 starts a scan and reloads it with 3, so with no ticks lost a scan starts on every third tick.
- R2: A scan first reads the word at TIME_ADDR (default 0x00E4). It then writes back that value plus one, modulo 2^16, before any record access.
- R3: The scan visits the record at first_rec_i, then every record 5 words further on while the address is at most last_rec_i. The first record is always visited. A visit starts with a read of the timeout word at record+2.
- R4: A record whose timeout word is zero is never requeued and its flags word is not accessed. This holds even when the new time is zero.
- R5: When the timeout word equals the new time, rq_req_o is raised with rq_rec_o equal to the record address and held until rq_ack_i. Only after that acknowledge does the block read the flags word at record+3.
- R6: For a requeued record, the flags word at record+3 is written back with bit 3 (value 8) cleared and every other bit unchanged.
- R7: A record whose nonzero timeout differs from the new time causes no requeue request and no flags access.
- R8: A tick that arrives during a scan is remembered and applied to the counter when the scan ends. Only one such tick is remembered, and further ticks during the same scan are lost.
- R9: When wait_len_i is nonzero, wait_deadline_o equals wait_now_i + wait_len_i modulo 2^16, or 1 if that sum is 0.
- R10: When wait_len_i is zero, wait_deadline_o is zero.
- R11: The memory request holds its address, direction and write data stable until mem_ack_i. Read data is taken in the acknowledge cycle. A memory request and a requeue request are never raised together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One-cycle time-base tick |
| first_rec_i | input | 16 | Address of the first record in the table |
| last_rec_i | input | 16 | Address of the last record in the table |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | 16 | Memory word address |
| mem_wdata_o | output | 16 | Write data |
| mem_rdata_i | input | 16 | Read data, valid with mem_ack_i |
| mem_ack_i | input | 1 | Memory access complete |
| rq_req_o | output | 1 | Requeue request for an expired record |
| rq_rec_o | output | 16 | Address of the record to requeue |
| rq_ack_i | input | 1 | Requeue done |
| wait_now_i | input | 16 | Current time for a deadline computation |
| wait_len_i | input | 16 | Wait interval, 0 = forever |
| wait_deadline_o | output | 16 | Deadline to store in the record |

## Verification
On every cycle, the bound checker enforces four properties. Both handshakes must stay stable until acknowledged and the two requests must never overlap. Every write to the time word must equal the last value read from it plus one. Every record write must have the waiting bit clear. The deadline output must obey the zero-interval and never-zero rules. Other behaviour is shown only by the bench's table scenarios, which compare a logged sequence of memory and requeue events with a model. Those scenarios cover the prescale count, the lost-versus-remembered ticks, the exact set and order of visited records, and which records match, including a time that wraps to zero.

// File: rtl/tmo_pkg.sv
package tmo_pkg;

    // Record layout and constants whose values the table format fixes
    localparam int unsigned REC_WORDS_DEF = 5;
    localparam int unsigned TMO_OFS_DEF   = 2;
    localparam int unsigned FLG_OFS_DEF   = 3;
    localparam int unsigned WAIT_BIT_DEF  = 3;
    localparam int unsigned TICK_RELOAD_DEF = 3;
    localparam logic [15:0] TIME_ADDR_DEF = 16'h00E4;

    typedef enum logic [2:0] {
        S_IDLE,
        S_TIME_RD,
        S_TIME_WR,
        S_TMO_RD,
        S_REQ,
        S_FLG_RD,
        S_FLG_WR,
        S_STEP
    } scan_state_e;

endpackage

// File: rtl/tmo_tick_prescaler.sv
module tmo_tick_prescaler #(
    parameter int unsigned RELOAD = tmo_pkg::TICK_RELOAD_DEF
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic busy_i,
    output logic start_o
);
    localparam int unsigned CNT_W = $clog2(RELOAD + 1);
    localparam logic [CNT_W-1:0] CNT_RELOAD = CNT_W'(RELOAD);
    localparam logic [CNT_W-1:0] CNT_ONE    = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             pend;
    } pre_regs_t;

    pre_regs_t q, d;
    logic      take;

    always_comb begin
        d       = q;
        take    = !busy_i && (q.pend || tick_i);
        start_o = 1'b0;

        // remember at most one tick while a scan is running
        if (busy_i) begin
            d.pend = q.pend | tick_i;
        end else if (q.pend) begin
            d.pend = tick_i;
        end else begin
            d.pend = 1'b0;
        end

        if (take) begin
            if (q.cnt == CNT_ONE) begin
                d.cnt   = CNT_RELOAD;
                start_o = 1'b1;
            end else begin
                d.cnt = q.cnt - CNT_ONE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.cnt  <= CNT_RELOAD;
            q.pend <= 1'b0;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/tmo_deadline_calc.sv
module tmo_deadline_calc #(
    parameter int unsigned DATA_W = 16
) (
    input  logic [DATA_W-1:0] now_i,
    input  logic [DATA_W-1:0] len_i,
    output logic [DATA_W-1:0] deadline_o
);
    localparam logic [DATA_W-1:0] ZERO = '0;
    localparam logic [DATA_W-1:0] ONE  = DATA_W'(1);

    logic [DATA_W-1:0] sum;

    always_comb begin
        sum = now_i + len_i;
        if (len_i == ZERO) begin
            deadline_o = ZERO;           // wait forever
        end else if (sum == ZERO) begin
            deadline_o = ONE;            // zero is reserved
        end else begin
            deadline_o = sum;
        end
    end

endmodule

// File: rtl/tmo_scan_fsm.sv
module tmo_scan_fsm
    import tmo_pkg::*;
#(
    parameter int unsigned ADDR_W    = 16,
    parameter int unsigned DATA_W    = 16,
    parameter int unsigned REC_WORDS = REC_WORDS_DEF,
    parameter int unsigned TMO_OFS   = TMO_OFS_DEF,
    parameter int unsigned FLG_OFS   = FLG_OFS_DEF,
    parameter int unsigned WAIT_BIT  = WAIT_BIT_DEF,
    parameter logic [ADDR_W-1:0] TIME_ADDR = ADDR_W'(TIME_ADDR_DEF)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] first_i,
    input  logic [ADDR_W-1:0] last_i,
    output logic              busy_o,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [DATA_W-1:0] mem_wdata_o,
    input  logic [DATA_W-1:0] mem_rdata_i,
    input  logic              mem_ack_i,
    output logic              rq_req_o,
    output logic [ADDR_W-1:0] rq_rec_o,
    input  logic              rq_ack_i
);
    localparam logic [ADDR_W-1:0] TMO_OFS_A = ADDR_W'(TMO_OFS);
    localparam logic [ADDR_W-1:0] FLG_OFS_A = ADDR_W'(FLG_OFS);
    localparam logic [ADDR_W:0]   STEP_A    = (ADDR_W+1)'(REC_WORDS);
    localparam logic [DATA_W-1:0] WAIT_MASK = DATA_W'(1) << WAIT_BIT;
    localparam logic [DATA_W-1:0] ONE_D     = DATA_W'(1);
    localparam logic [DATA_W-1:0] ZERO_D    = '0;

    typedef struct packed {
        scan_state_e       st;
        logic [ADDR_W-1:0] rec;
        logic [ADDR_W-1:0] last;
        logic [DATA_W-1:0] now;
        logic [DATA_W-1:0] data;
    } scan_regs_t;

    scan_regs_t q, d;
    logic [ADDR_W:0] nxt_rec;
    logic            tmo_hit;

    // next-state computation
    always_comb begin
        d       = q;
        nxt_rec = {1'b0, q.rec} + STEP_A;
        tmo_hit = (mem_rdata_i != ZERO_D) && (mem_rdata_i == q.now);

        unique case (q.st)
            S_IDLE: begin
                if (start_i) begin
                    d.rec  = first_i;
                    d.last = last_i;
                    d.st   = S_TIME_RD;
                end
            end
            S_TIME_RD: begin
                if (mem_ack_i) begin
                    d.now = mem_rdata_i + ONE_D;
                    d.st  = S_TIME_WR;
                end
            end
            S_TIME_WR: begin
                if (mem_ack_i) begin
                    d.st = S_TMO_RD;
                end
            end
            S_TMO_RD: begin
                if (mem_ack_i) begin
                    d.st = tmo_hit ? S_REQ : S_STEP;
                end
            end
            S_REQ: begin
                if (rq_ack_i) begin
                    d.st = S_FLG_RD;
                end
            end
            S_FLG_RD: begin
                if (mem_ack_i) begin
                    d.data = mem_rdata_i;
                    d.st   = S_FLG_WR;
                end
            end
            S_FLG_WR: begin
                if (mem_ack_i) begin
                    d.st = S_STEP;
                end
            end
            S_STEP: begin
                if (nxt_rec <= {1'b0, q.last}) begin
                    d.rec = nxt_rec[ADDR_W-1:0];
                    d.st  = S_TMO_RD;
                end else begin
                    d.st = S_IDLE;
                end
            end
            default: d.st = S_IDLE;
        endcase
    end

    // port drive, decoded from the registered state only
    always_comb begin
        mem_req_o   = 1'b0;
        mem_we_o    = 1'b0;
        mem_addr_o  = TIME_ADDR;
        mem_wdata_o = q.now;
        rq_req_o    = 1'b0;
        rq_rec_o    = q.rec;

        unique case (q.st)
            S_TIME_RD: begin
                mem_req_o = 1'b1;
            end
            S_TIME_WR: begin
                mem_req_o = 1'b1;
                mem_we_o  = 1'b1;
            end
            S_TMO_RD: begin
                mem_req_o  = 1'b1;
                mem_addr_o = q.rec + TMO_OFS_A;
            end
            S_REQ: begin
                rq_req_o = 1'b1;
            end
            S_FLG_RD: begin
                mem_req_o  = 1'b1;
                mem_addr_o = q.rec + FLG_OFS_A;
            end
            S_FLG_WR: begin
                mem_req_o   = 1'b1;
                mem_we_o    = 1'b1;
                mem_addr_o  = q.rec + FLG_OFS_A;
                mem_wdata_o = q.data & ~WAIT_MASK;
            end
            default: begin
                mem_req_o = 1'b0;
            end
        endcase
    end

    assign busy_o = (q.st != S_IDLE);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.st   <= S_IDLE;
            q.rec  <= '0;
            q.last <= '0;
            q.now  <= '0;
            q.data <= '0;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/tmo_scanner.sv
module tmo_scanner
    import tmo_pkg::*;
#(
    parameter int unsigned ADDR_W      = 16,
    parameter int unsigned DATA_W      = 16,
    parameter int unsigned TICK_RELOAD = TICK_RELOAD_DEF,
    parameter int unsigned REC_WORDS   = REC_WORDS_DEF,
    parameter int unsigned TMO_OFS     = TMO_OFS_DEF,
    parameter int unsigned FLG_OFS     = FLG_OFS_DEF,
    parameter int unsigned WAIT_BIT    = WAIT_BIT_DEF,
    parameter logic [ADDR_W-1:0] TIME_ADDR = ADDR_W'(TIME_ADDR_DEF)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic [ADDR_W-1:0] first_rec_i,
    input  logic [ADDR_W-1:0] last_rec_i,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [DATA_W-1:0] mem_wdata_o,
    input  logic [DATA_W-1:0] mem_rdata_i,
    input  logic              mem_ack_i,
    output logic              rq_req_o,
    output logic [ADDR_W-1:0] rq_rec_o,
    input  logic              rq_ack_i,
    input  logic [DATA_W-1:0] wait_now_i,
    input  logic [DATA_W-1:0] wait_len_i,
    output logic [DATA_W-1:0] wait_deadline_o
);
    logic scan_start;
    logic scan_busy;

    tmo_tick_prescaler #(
        .RELOAD (TICK_RELOAD)
    ) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (tick_i),
        .busy_i  (scan_busy),
        .start_o (scan_start)
    );

    tmo_scan_fsm #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .REC_WORDS (REC_WORDS),
        .TMO_OFS   (TMO_OFS),
        .FLG_OFS   (FLG_OFS),
        .WAIT_BIT  (WAIT_BIT),
        .TIME_ADDR (TIME_ADDR)
    ) u_scan (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (scan_start),
        .first_i     (first_rec_i),
        .last_i      (last_rec_i),
        .busy_o      (scan_busy),
        .mem_req_o   (mem_req_o),
        .mem_we_o    (mem_we_o),
        .mem_addr_o  (mem_addr_o),
        .mem_wdata_o (mem_wdata_o),
        .mem_rdata_i (mem_rdata_i),
        .mem_ack_i   (mem_ack_i),
        .rq_req_o    (rq_req_o),
        .rq_rec_o    (rq_rec_o),
        .rq_ack_i    (rq_ack_i)
    );

    tmo_deadline_calc #(
        .DATA_W (DATA_W)
    ) u_dl (
        .now_i      (wait_now_i),
        .len_i      (wait_len_i),
        .deadline_o (wait_deadline_o)
    );

endmodule

// File: rtl/tmo_scanner_chk.sv
module tmo_scanner_chk #(
    parameter int unsigned ADDR_W   = 16,
    parameter int unsigned DATA_W   = 16,
    parameter int unsigned WAIT_BIT = 3,
    parameter logic [ADDR_W-1:0] TIME_ADDR = '0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_req_o,
    input logic              mem_we_o,
    input logic [ADDR_W-1:0] mem_addr_o,
    input logic [DATA_W-1:0] mem_wdata_o,
    input logic [DATA_W-1:0] mem_rdata_i,
    input logic              mem_ack_i,
    input logic              rq_req_o,
    input logic [ADDR_W-1:0] rq_rec_o,
    input logic              rq_ack_i,
    input logic [DATA_W-1:0] wait_len_i,
    input logic [DATA_W-1:0] wait_deadline_o
);
    logic              tvld_q;
    logic [DATA_W-1:0] tval_q;

    // last value read from the time word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tvld_q <= 1'b0;
            tval_q <= '0;
        end else if (mem_req_o && mem_ack_i && !mem_we_o && mem_addr_o == TIME_ADDR) begin
            tvld_q <= 1'b1;
            tval_q <= mem_rdata_i;
        end
    end

    AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o) && $stable(mem_wdata_o))); // R11
    AST_RQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rq_req_o && !rq_ack_i) |=> (rq_req_o && $stable(rq_rec_o))); // R5
    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_req_o && rq_req_o)); // R11
    AST_TIME_INC: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && mem_we_o && mem_addr_o == TIME_ADDR) |-> (tvld_q && mem_wdata_o == DATA_W'(tval_q + DATA_W'(1)))); // R2
    AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && mem_we_o && mem_addr_o != TIME_ADDR) |-> !mem_wdata_o[WAIT_BIT]); // R6
    AST_DL_FOREVER: assert property (@(posedge clk) disable iff (!rst_n)
        (wait_len_i == '0) |-> (wait_deadline_o == '0)); // R10
    AST_DL_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (wait_len_i != '0) |-> (wait_deadline_o != '0)); // R9

endmodule

bind tmo_scanner tmo_scanner_chk #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .WAIT_BIT  (WAIT_BIT),
    .TIME_ADDR (TIME_ADDR)
) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .mem_req_o       (mem_req_o),
    .mem_we_o        (mem_we_o),
    .mem_addr_o      (mem_addr_o),
    .mem_wdata_o     (mem_wdata_o),
    .mem_rdata_i     (mem_rdata_i),
    .mem_ack_i       (mem_ack_i),
    .rq_req_o        (rq_req_o),
    .rq_rec_o        (rq_rec_o),
    .rq_ack_i        (rq_ack_i),
    .wait_len_i      (wait_len_i),
    .wait_deadline_o (wait_deadline_o)
);

// File: tb/tmo_scanner_tb.sv
module tmo_scanner_tb;
    localparam int CLK_PERIOD = 10;
    localparam int TA = 16'h00E4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic [15:0] first_rec = 16'd16;
    logic [15:0] last_rec = 16'd41;
    logic        mem_req, mem_we, mem_ack = 1'b0;
    logic [15:0] mem_addr, mem_wdata, mem_rdata = '0;
    logic        rq_req, rq_ack = 1'b0;
    logic [15:0] rq_rec;
    logic [15:0] wait_now = '0, wait_len = '0, wait_dl;

    int checks = 0;
    int failures = 0;

    logic [15:0] mem [0:255];
    logic [15:0] exp_mem [0:255];
    logic [17:0] ev_log [0:255];
    logic [17:0] exp_ev [0:255];
    int ev_n = 0;
    int exp_n = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tmo_scanner u_dut (
        .clk (clk), .rst_n (rst_n), .tick_i (tick),
        .first_rec_i (first_rec), .last_rec_i (last_rec),
        .mem_req_o (mem_req), .mem_we_o (mem_we), .mem_addr_o (mem_addr),
        .mem_wdata_o (mem_wdata), .mem_rdata_i (mem_rdata), .mem_ack_i (mem_ack),
        .rq_req_o (rq_req), .rq_rec_o (rq_rec), .rq_ack_i (rq_ack),
        .wait_now_i (wait_now), .wait_len_i (wait_len), .wait_deadline_o (wait_dl)
    );

    // memory and requeue responders; kinds: 0 read, 1 write, 2 requeue
    always @(negedge clk) begin
        if (!rst_n) begin
            mem_ack = 1'b0;
            rq_ack  = 1'b0;
        end else begin
            if (mem_ack) mem_ack = 1'b0;
            else if (mem_req) begin
                if (ev_n < 256) ev_log[ev_n] = {1'b0, mem_we, mem_addr};
                ev_n++;
                if (mem_we) mem[mem_addr[7:0]] = mem_wdata;
                else mem_rdata = mem[mem_addr[7:0]];
                mem_ack = 1'b1;
            end
            if (rq_ack) rq_ack = 1'b0;
            else if (rq_req) begin
                if (ev_n < 256) ev_log[ev_n] = {2'd2, rq_rec};
                ev_n++;
                rq_ack = 1'b1;
            end
        end
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic do_tick();
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
    endtask

    task automatic settle();
        repeat (400) @(negedge clk);
    endtask

    task automatic add_ev(input logic [17:0] e);
        exp_ev[exp_n] = e;
        exp_n++;
    endtask

    task automatic set_rec(input int r, input logic [15:0] tmo, input logic [15:0] flg);
        mem[r+2] = tmo;
        mem[r+3] = flg;
    endtask

    // model of one scan over [first,last], built before the triggering tick
    task automatic prep_expect(input int first, input int last);
        logic [15:0] tnew;
        int r;
        for (int i = 0; i < 256; i++) exp_mem[i] = mem[i];
        tnew = mem[TA] + 16'd1;
        exp_mem[TA] = tnew;
        exp_n = 0;
        ev_n = 0;
        add_ev({2'd0, 16'(TA)});
        add_ev({2'd1, 16'(TA)});
        r = first;
        do begin
            add_ev({2'd0, 16'(r + 2)});
            if (exp_mem[r+2] != 16'd0 && exp_mem[r+2] == tnew) begin
                add_ev({2'd2, 16'(r)});
                add_ev({2'd0, 16'(r + 3)});
                add_ev({2'd1, 16'(r + 3)});
                exp_mem[r+3] = exp_mem[r+3] & ~16'h0008;
            end
            r += 5;
        end while (r <= last);
    endtask

    task automatic check_scan(input string tag);
        int bad;
        int rq_act, rq_exp;
        check("R3", {tag, " event count"}, ev_n, exp_n);
        bad = -1;
        for (int i = 0; i < exp_n && i < ev_n; i++)
            if (bad < 0 && ev_log[i] != exp_ev[i]) bad = i;
        if (bad >= 0) check("R5", {tag, " event sequence"}, int'(ev_log[bad]), int'(exp_ev[bad]));
        else check("R5", {tag, " event sequence"}, 0, 0);
        rq_act = 0; rq_exp = 0;
        for (int i = 0; i < ev_n && i < 256; i++) if (ev_log[i][17:16] == 2'd2) rq_act++;
        for (int i = 0; i < exp_n; i++) if (exp_ev[i][17:16] == 2'd2) rq_exp++;
        check("R5", {tag, " requeue count"}, rq_act, rq_exp);
        check("R2", {tag, " time word"}, int'(mem[TA]), int'(exp_mem[TA]));
        bad = -1;
        for (int i = 0; i < 256; i++) if (bad < 0 && mem[i] != exp_mem[i]) bad = i;
        if (bad >= 0) check("R6", {tag, " memory word"}, int'(mem[bad]), int'(exp_mem[bad]));
        else check("R6", {tag, " memory image"}, 0, 0);
    endtask

    task automatic scan_range(input int first, input int last, input string tag);
        first_rec = 16'(first);
        last_rec  = 16'(last);
        do_tick(); do_tick();
        prep_expect(first, last);
        do_tick();
        settle();
        check_scan(tag);
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        failures++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        logic [15:0] nows [0:7];
        logic [15:0] lv, expd;
        int dl_bad;
        for (int i = 0; i < 256; i++) mem[i] = 16'(i * 7 + 3);
        repeat (4) @(negedge clk);
        // reset state: no requests (R1, R11)
        check("R11", "reset mem_req", int'(mem_req), 0);
        check("R5", "reset rq_req", int'(rq_req), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // deadline sweep (R9, R10)
        nows[0] = 16'h0000; nows[1] = 16'h0001; nows[2] = 16'h0002; nows[3] = 16'h1234;
        nows[4] = 16'h7FFF; nows[5] = 16'h8000; nows[6] = 16'hFFFE; nows[7] = 16'hFFFF;
        dl_bad = 0;
        for (int n = 0; n < 8; n++) begin
            for (int k = 0; k < 512; k++) begin
                lv = (k < 256) ? 16'(k) : 16'(16'hFF00 + (k - 256));
                wait_now = nows[n];
                wait_len = lv;
                #1;
                expd = wait_now + lv;
                if (lv == 16'd0) expd = 16'd0;
                else if (expd == 16'd0) expd = 16'd1;
                if (lv == 16'd0) check("R10", "deadline forever", int'(wait_dl), int'(expd));
                else check("R9", "deadline sum", int'(wait_dl), int'(expd));
                if (wait_dl != expd) dl_bad++;
            end
        end
        check("R9", "deadline sweep mismatches", dl_bad, 0);
        wait_len = 16'd0;

        // table at 16..41, time 100
        mem[TA] = 16'd100;
        set_rec(16, 16'd101, 16'h000F);   // match
        set_rec(21, 16'd0,   16'h000F);   // zero: skipped (R4)
        set_rec(26, 16'd102, 16'h000D);   // other time (R7)
        set_rec(31, 16'd101, 16'h00F8);   // match
        set_rec(36, 16'd5,   16'h0008);
        set_rec(41, 16'd101, 16'h0007);   // match, bit already clear
        first_rec = 16'd16; last_rec = 16'd41;
        ev_n = 0;
        do_tick(); do_tick();
        repeat (20) @(negedge clk);
        check("R1", "no access after two ticks", ev_n, 0);
        check("R1", "time unchanged after two ticks", int'(mem[TA]), 100);
        prep_expect(16, 41);
        do_tick();
        settle();
        check_scan("basic");
        check("R4", "zero-timeout flags untouched", int'(mem[24]), 16'h000F);
        check("R7", "other-time flags untouched", int'(mem[29]), 16'h000D);
        check("R6", "match flags bit3 cleared", int'(mem[19]), 16'h0007);

        // wrap to zero: zero timeouts never match (R4)
        mem[TA] = 16'hFFFF;
        set_rec(16, 16'd0, 16'h000F);
        set_rec(31, 16'hFFFF, 16'h000F);
        scan_range(16, 41, "wrap");
        check("R4", "wrap time is zero", int'(mem[TA]), 0);
        check("R4", "zero timeout at time zero flags", int'(mem[19]), 16'h000F);

        // pending tick (R8): time now 0, matches at 1
        set_rec(21, 16'd1, 16'h000A);
        set_rec(36, 16'd1, 16'h0009);
        first_rec = 16'd16; last_rec = 16'd41;
        do_tick(); do_tick();
        prep_expect(16, 41);
        do_tick();
        do_tick(); do_tick();           // during scan: one kept, one lost
        settle();
        check_scan("pending");
        ev_n = 0;
        do_tick();
        repeat (30) @(negedge clk);
        check("R8", "lost tick keeps counter", ev_n, 0);
        set_rec(26, 16'd2, 16'h00FF);
        prep_expect(16, 41);
        do_tick();
        settle();
        check_scan("after pending");
        check("R8", "scan after remembered tick", int'(mem[TA]), 2);

        // range corners (R3)
        set_rec(16, 16'd3, 16'h0008);
        scan_range(16, 16, "single");
        set_rec(21, 16'd4, 16'h0008);
        scan_range(16, 23, "partial step");
        set_rec(41, 16'd5, 16'h0018);
        scan_range(41, 16, "first above last");
        check("R3", "first record always visited", int'(mem[44]), 16'h0010);

        summary();
        $finish;
    end

endmodule